// File: doc/BRIEF.md
# Programmable-Depth Display Dither Stage

This stage sits at the end of a pixel pipeline and narrows 10-bit-per-channel RGB to the depth a panel can physically show. Each of the red, green and blue channels can be set to 5, 6, 7 or 8 bits independently. The bits that are dropped form a fraction. That fraction is compared with an ordered 4x4 threshold to decide whether the kept code stays as it is or steps up by one. The panel therefore sees a mix of the two nearest physical codes, and over an area or over time that mix approximates the 10-bit value.

The threshold can come from the pixel position alone (spatial mode). It can also come from the position shifted by a 2-bit frame counter (temporal mode), which changes the pattern from frame to frame. A per-pixel enable bit bypasses the dither and gives a plain truncation. The result is left-aligned in an 8-bit field per channel.

Pixels enter and leave on valid/ready streams through a single output register. A pixel is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no new pixel is taken. The configuration inputs and `frame_start` are plain level/strobe pins.

Top module: `pix_dither_top`

## Requirements
- R1: Each channel has its own 2-bit depth select, decoded as 00=5, 01=6, 10=7 and 11=8 output bits, and a channel's select affects only that channel.
- R2: Every output channel is an 8-bit field with the kept code in its upper bits and all lower unused bits zero.
- R3: The kept code equals either the truncated input (the input shifted right by 10 minus depth) or that value plus one, and it never exceeds the all-ones code for its depth (saturation, no wrap).
- R4: When `in_alpha` is 0 the output of every channel is the plain truncation of the input.
- R5: In spatial mode (`cfg_temporal`=0) with `in_alpha`=1, the fraction (the dropped bits, scaled to 4 bits by discarding its LSB for 5 dropped bits, used as-is for 4, or left-shifted with zero fill for 3 or 2) rounds the code up exactly when it is strictly greater than T(i,j), where i=x mod 4, j=y mod 4. T is defined by rows j=0..3 as [0 8 2 10], [12 4 14 6], [3 11 1 9] and [15 7 13 5], with column i.
- R6: In temporal mode (`cfg_temporal`=1) the same rule applies, with index i=(x+f) mod 4 and j=(y+f) mod 4, where f is the frame counter.
- R7: The frame counter is 2 bits wide and advances by one, wrapping, on each cycle with `frame_start` high. A pixel accepted in the same cycle as the strobe uses the value from before the advance.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and all output channels stay unchanged.
- R9: After reset `out_valid` is 0 and the frame counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_temporal | input | 1 | 0 spatial threshold, 1 frame-varying threshold |
| cfg_depth_r | input | 2 | red output depth select |
| cfg_depth_g | input | 2 | green output depth select |
| cfg_depth_b | input | 2 | blue output depth select |
| frame_start | input | 1 | one-cycle strobe that advances the frame counter |
| in_valid | input | 1 | input pixel valid |
| in_ready | output | 1 | input pixel accepted when high with in_valid |
| in_r | input | 10 | red input code |
| in_g | input | 10 | green input code |
| in_b | input | 10 | blue input code |
| in_alpha | input | 1 | per-pixel dither enable |
| in_x | input | 12 | pixel column |
| in_y | input | 12 | pixel row |
| out_valid | output | 1 | output pixel valid |
| out_ready | input | 1 | downstream can take the output pixel |
| out_r | output | 8 | red result, left-aligned |
| out_g | output | 8 | green result, left-aligned |
| out_b | output | 8 | blue result, left-aligned |

## Verification
The counter advance and a pixel hand-off can fall in the same cycle. When they do, the pixel must use the counter value from before the advance. The bench provokes this with a directed temporal-mode pair. It uses code 0x101 at depth 8 at position (0,0): that fraction rounds up under offset 0 but not under offset 1. The first pixel is sent together with `frame_start` and must round up, and the next pixel must not. The random phase also raises the strobe on some accepted pixels, and a bench model that advances its own counter only after it has computed the expected value judges each result. A second collision, a stall arriving while a new pixel is offered, is checked by observing `in_ready` low and the held output.

// File: rtl/dith_pkg.sv
package dith_pkg;

  // Index of the three colour lanes inside packed per-pixel arrays.
  localparam int LANES = 3;

  // Ordered 4x4 threshold. Bit-interleaved construction: the MSB comes
  // from the low bit of (col ^ row), then the low row bit, then the
  // high bit of (col ^ row), then the high row bit.
  function automatic logic [3:0] ordered_thr(input logic [1:0] col,
                                             input logic [1:0] row);
    logic [1:0] mix;
    mix = col ^ row;
    return {mix[0], row[0], mix[1], row[1]};
  endfunction

endpackage

// File: rtl/dith_fcnt.sv
module dith_fcnt #(
  parameter int FC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [FC_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= count + FC_W'(1);
    end
  end

endmodule

// File: rtl/dith_thresh.sv
module dith_thresh #(
  parameter int FC_W = 2,
  parameter int TH_W = 4
) (
  input  logic [1:0]      x_lo,
  input  logic [1:0]      y_lo,
  input  logic [FC_W-1:0] frame,
  input  logic            temporal,
  output logic [TH_W-1:0] thr
);
  import dith_pkg::*;

  logic [1:0] off;
  logic [1:0] col;
  logic [1:0] row;

  always_comb begin
    off = temporal ? frame[1:0] : 2'd0;
    col = x_lo + off;
    row = y_lo + off;
    thr = TH_W'(ordered_thr(col, row));
  end

endmodule

// File: rtl/dith_chan.sv
module dith_chan #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8,
  parameter int TH_W  = 4,
  parameter int SEL_W = 2
) (
  input  logic [IN_W-1:0]  code,
  input  logic [SEL_W-1:0] depth_sel,
  input  logic             enable,
  input  logic [TH_W-1:0]  thr,
  output logic [OUT_W-1:0] result
);
  localparam int NVAR  = 1 << SEL_W;
  localparam int MIN_D = OUT_W - NVAR + 1;

  logic [NVAR-1:0][OUT_W-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < NVAR; g++) begin : g_var
      localparam int D = MIN_D + g;
      localparam int K = IN_W - D;
      logic [D-1:0]    kept;
      logic [K-1:0]    frac;
      logic [TH_W-1:0] frac_n;
      logic            bump;
      logic [D-1:0]    sum;

      assign kept = code[IN_W-1:K];
      assign frac = code[K-1:0];

      if (K >= TH_W) begin : g_wide
        assign frac_n = frac[K-1 -: TH_W];
      end else begin : g_narrow
        assign frac_n = {frac, {(TH_W-K){1'b0}}};
      end

      always_comb begin
        bump = enable && (frac_n > thr) && (kept != {D{1'b1}});
        sum  = kept + D'(bump);
        cand[g] = OUT_W'(sum) << (OUT_W - D);
      end
    end
  endgenerate

  assign result = cand[depth_sel];

endmodule

// File: rtl/pix_dither_top.sv
module pix_dither_top #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8,
  parameter int XY_W  = 12,
  parameter int SEL_W = 2,
  parameter int FC_W  = 2,
  parameter int TH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_temporal,
  input  logic [SEL_W-1:0] cfg_depth_r,
  input  logic [SEL_W-1:0] cfg_depth_g,
  input  logic [SEL_W-1:0] cfg_depth_b,
  input  logic             frame_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_r,
  input  logic [IN_W-1:0]  in_g,
  input  logic [IN_W-1:0]  in_b,
  input  logic             in_alpha,
  input  logic [XY_W-1:0]  in_x,
  input  logic [XY_W-1:0]  in_y,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_g,
  output logic [OUT_W-1:0] out_b
);
  import dith_pkg::*;

  logic [FC_W-1:0] fc_q;
  logic [TH_W-1:0] thr;
  logic            accept;

  logic [LANES-1:0][IN_W-1:0]  lane_in;
  logic [LANES-1:0][SEL_W-1:0] lane_sel;
  logic [LANES-1:0][OUT_W-1:0] lane_res;
  logic [LANES-1:0][OUT_W-1:0] lane_q;

  assign lane_in  = {in_b, in_g, in_r};
  assign lane_sel = {cfg_depth_b, cfg_depth_g, cfg_depth_r};

  dith_fcnt #(.FC_W(FC_W)) u_fcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (frame_start),
    .count (fc_q)
  );

  dith_thresh #(.FC_W(FC_W), .TH_W(TH_W)) u_thr (
    .x_lo     (in_x[1:0]),
    .y_lo     (in_y[1:0]),
    .frame    (fc_q),
    .temporal (cfg_temporal),
    .thr      (thr)
  );

  genvar ch;
  generate
    for (ch = 0; ch < LANES; ch++) begin : g_lane
      dith_chan #(
        .IN_W(IN_W), .OUT_W(OUT_W), .TH_W(TH_W), .SEL_W(SEL_W)
      ) u_chan (
        .code      (lane_in[ch]),
        .depth_sel (lane_sel[ch]),
        .enable    (in_alpha),
        .thr       (thr),
        .result    (lane_res[ch])
      );
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else if (accept) begin
      lane_q <= lane_res;
    end
  end

  assign out_r = lane_q[0];
  assign out_g = lane_q[1];
  assign out_b = lane_q[2];

endmodule

// File: rtl/dith_chk.sv
module dith_chk #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8,
  parameter int SEL_W = 2,
  parameter int FC_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] cfg_depth_r,
  input logic             frame_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_r,
  input logic             in_alpha,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_r,
  input logic [OUT_W-1:0] out_g,
  input logic [OUT_W-1:0] out_b,
  input logic [FC_W-1:0]  fc_q
);
  localparam int MIN_D = OUT_W - (1 << SEL_W) + 1;

  function automatic int kept_val(input logic [OUT_W-1:0] o, input logic [SEL_W-1:0] s);
    return int'(o) >> (OUT_W - (MIN_D + int'(s)));
  endfunction

  function automatic int trunc_val(input logic [IN_W-1:0] c, input logic [SEL_W-1:0] s);
    return int'(c) >> (IN_W - (MIN_D + int'(s)));
  endfunction

  function automatic bit low_zero(input logic [OUT_W-1:0] o, input logic [SEL_W-1:0] s);
    int pad;
    pad = OUT_W - (MIN_D + int'(s));
    return (int'(o) & ((1 << pad) - 1)) == 0;
  endfunction

  function automatic bit near(input logic [OUT_W-1:0] o, input logic [IN_W-1:0] c,
                              input logic [SEL_W-1:0] s);
    int v, t;
    v = kept_val(o, s);
    t = trunc_val(c, s);
    return (v == t) || (v == t + 1 && v <= (1 << (MIN_D + int'(s))) - 1);
  endfunction

  // R2
  p_lsb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> low_zero(out_r, $past(cfg_depth_r)));

  // R3
  p_near_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> near(out_r, $past(in_r), $past(cfg_depth_r)));

  // R4
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_alpha) |=>
      (kept_val(out_r, $past(cfg_depth_r)) == trunc_val($past(in_r), $past(cfg_depth_r))));

  // R7
  p_fc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fc_q == $past(fc_q) + FC_W'(1)));

  p_fc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fc_q));

  // R8
  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

endmodule

bind pix_dither_top dith_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .SEL_W(SEL_W), .FC_W(FC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_depth_r (cfg_depth_r),
  .frame_start (frame_start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_r        (in_r),
  .in_alpha    (in_alpha),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_r       (out_r),
  .out_g       (out_g),
  .out_b       (out_b),
  .fc_q        (fc_q)
);

// File: tb/sim_pix_dither_top.sv
module sim_pix_dither_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_temporal = 1'b0;
  logic [1:0] cfg_depth_r = '0, cfg_depth_g = '0, cfg_depth_b = '0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_alpha = 1'b0;
  logic [11:0] in_x = '0, in_y = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_r, out_g, out_b;

  int total = 0;
  int bad = 0;
  logic [1:0] fc_m = 2'd0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_dither_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_temporal(cfg_temporal),
    .cfg_depth_r(cfg_depth_r), .cfg_depth_g(cfg_depth_g), .cfg_depth_b(cfg_depth_b),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_alpha(in_alpha),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic int thr_tab(input int col, input int row);
    int t [16] = '{0, 8, 2, 10, 12, 4, 14, 6, 3, 11, 1, 9, 15, 7, 13, 5};
    return t[row*4 + col];
  endfunction

  function automatic logic [7:0] model(input int code, input int sel, input bit en,
                                       input int x, input int y, input int fc, input bit tmp);
    int d, k, q, f, f4, col, row, up;
    d = 5 + sel;
    k = 10 - d;
    q = code >> k;
    f = code & ((1 << k) - 1);
    f4 = (k >= 4) ? (f >> (k - 4)) : (f << (4 - k));
    col = tmp ? ((x + fc) & 3) : (x & 3);
    row = tmp ? ((y + fc) & 3) : (y & 3);
    up = (en && f4 > thr_tab(col, row) && q < (1 << d) - 1) ? 1 : 0;
    return 8'((q + up) << (8 - d));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input int r, input int g, input int b,
                      input bit en, input int x, input int y, input bit fs);
    logic [7:0] er, eg, eb;
    er = model(r, int'(cfg_depth_r), en, x, y, int'(fc_m), cfg_temporal);
    eg = model(g, int'(cfg_depth_g), en, x, y, int'(fc_m), cfg_temporal);
    eb = model(b, int'(cfg_depth_b), en, x, y, int'(fc_m), cfg_temporal);
    @(negedge clk);
    in_r = 10'(r); in_g = 10'(g); in_b = 10'(b);
    in_alpha = en; in_x = 12'(x); in_y = 12'(y);
    in_valid = 1'b1; frame_start = fs;
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
    if (fs) fc_m = fc_m + 2'd1;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " r"}, int'(out_r), int'(er));
    check({req, " g"}, int'(out_g), int'(eg));
    check({req, " b"}, int'(out_b), int'(eb));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R8 in_ready idle", int'(in_ready), 1);

    // R1 / R2: per-lane depth, alignment, bypass R4
    cfg_depth_r = 2'd0; cfg_depth_g = 2'd1; cfg_depth_b = 2'd3;
    send("R1 R4 mixed depth trunc", 10'h2ff, 10'h2ff, 10'h2ff, 1'b0, 0, 0, 1'b0);
    cfg_depth_r = 2'd2; cfg_depth_g = 2'd3; cfg_depth_b = 2'd0;
    send("R2 R1 lane swap", 10'h155, 10'h3aa, 10'h0f0, 1'b0, 1, 2, 1'b0);

    // R3 saturation at full code
    cfg_depth_r = 2'd0; cfg_depth_g = 2'd1; cfg_depth_b = 2'd3;
    send("R3 saturate", 10'h3ff, 10'h3ff, 10'h3ff, 1'b1, 0, 0, 1'b0);
    check("R3 saturate r literal", int'(out_r), 'hf8);

    // R5 spatial threshold: fraction 0x8 at depth 8 -> f4=8
    cfg_depth_r = 2'd3; cfg_depth_g = 2'd3; cfg_depth_b = 2'd3;
    cfg_temporal = 1'b0;
    send("R5 spatial (1,0) thr8", 10'h102, 10'h102, 10'h102, 1'b1, 1, 0, 1'b0);
    check("R5 no round at equal", int'(out_r), 'h40);
    send("R5 spatial (2,0) thr2", 10'h102, 10'h102, 10'h102, 1'b1, 2, 0, 1'b0);
    check("R5 round above", int'(out_r), 'h41);

    // R6 / R7 temporal with strobe in same cycle as pixel
    cfg_temporal = 1'b1;
    send("R7 strobe collision", 10'h101, 10'h101, 10'h101, 1'b1, 0, 0, 1'b1);
    check("R7 old counter used", int'(out_r), 'h41);
    send("R6 next frame offset", 10'h101, 10'h101, 10'h101, 1'b1, 0, 0, 1'b0);
    check("R6 offset one", int'(out_r), 'h40);

    // R8 stall
    @(negedge clk);
    out_ready = 1'b0;
    in_r = 10'h200; in_g = 10'h100; in_b = 10'h080; in_alpha = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_r = 10'h3c0; in_g = 10'h3c0; in_b = 10'h3c0;
    check("R8 in_ready low on stall", int'(in_ready), 0);
    check("R8 held r", int'(out_r), 'h80);
    @(negedge clk);
    check("R8 still held r", int'(out_r), 'h80);
    check("R8 still valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next pixel r", int'(out_r), 'hf0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      cfg_depth_r = 2'($urandom); cfg_depth_g = 2'($urandom); cfg_depth_b = 2'($urandom);
      cfg_temporal = 1'($urandom);
      send("R5 R6 R7 random", int'($urandom & 10'h3ff), int'($urandom & 10'h3ff),
           int'($urandom & 10'h3ff), 1'($urandom), int'($urandom & 12'hfff),
           int'($urandom & 12'hfff), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule